// File: doc/BRIEF.md
# Memory Type Range Lookup Unit

This block resolves the cache memory type of a physical address span. It holds a register image made of a default-type word with two enable bits, 88 fixed-range type bytes covering the first megabyte at three granularities, and a set of variable ranges, each described by a base word and a mask word. Software-side logic programs these through a simple write port. A requester presents a start address and an inclusive end address on a valid/ready query port. One cycle after acceptance the block returns the resolved type.

When several variable ranges cover the start address, their types are merged by a fixed precedence rule. When the queried span crosses the edge of an active variable range, the block also raises a split flag and returns a partial-end address. The requester then re-issues the query from that point. A split point that would not advance past the start is pushed forward by one 4 KiB page, so repeated queries always make progress.

Top module: `memtype_lookup`

## Requirements
- R1: After reset the response port is empty (r_valid_o low, q_ready_o high), and until the default-type word has been written once, every query returns type 0xFF with the split flag low.
- R2: While bit 11 of the default-type word (global enable) is clear, every query returns 0xFF with the split flag low.
- R3: With bit 10 (fixed enable) and bit 11 set, a start address below 0x80000 returns fixed entry start>>16 (entries 0..7).
- R4: With fixed ranges enabled, a start address in 0x80000..0xBFFFF returns fixed entry 8 + ((start-0x80000)>>14).
- R5: With fixed ranges enabled, a start address in 0xC0000..0xFFFFF returns fixed entry 24 + ((start-0xC0000)>>12).
- R6: With bit 10 clear, the fixed entries have no effect and the variable ranges and default type (bits 7:0 of the default word) decide.
- R7: A variable range takes part only when bit 11 of its mask word is set. The start matches when (start & mask) equals (base & mask), with bits 11:0 of both words cleared. The range type is base bits 7:0.
- R8: When no active variable range matches the start, the default type is returned.
- R9: Several matching types merge as follows. Uncacheable (0x00) with anything gives 0x00. Write-back (0x06) with write-through (0x04) gives 0x04. Equal types stay as they are. Any other differing pair gives 0x00.
- R10: If start and end match a range differently, the split flag is set. The partial end is base + (two's complement of the page-masked mask) when the start matched, else base, and the end is pulled in to partial end - 1 for later ranges.
- R11: A partial end at or below the start is replaced by start + 0x1000.
- R12: A query is accepted when q_valid_i and q_ready_o are both high. Its result appears in the following cycle and is held stable while r_valid_o is high and r_ready_i is low, during which q_ready_o is low.
- R13: A query accepted in the same cycle as a register write is resolved with the state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 2 | Write target: 0 default word, 1 fixed entry, 2 range base, 3 range mask |
| wr_idx_i | input | 7 | Fixed entry index or variable range index |
| wr_data_i | input | ADDR_W | Write data (fixed entries use bits 7:0) |
| q_valid_i | input | 1 | Query valid |
| q_ready_o | output | 1 | Query can be accepted |
| q_start_i | input | ADDR_W | Query start address |
| q_end_i | input | ADDR_W | Query inclusive end address |
| r_valid_o | output | 1 | Result valid |
| r_ready_i | input | 1 | Result consumed |
| r_type_o | output | 8 | Resolved memory type |
| r_split_o | output | 1 | Span crosses a range edge |
| r_part_end_o | output | ADDR_W | Start of the remaining span when split |

## Verification
A register write and a query acceptance can land on the same clock edge. The bench provokes this by driving a fixed-entry write and a query for that entry in one cycle. It expects the old byte from that query and the new byte from the next one. The second overlap is the release of a stalled result together with the acceptance of a waiting query. The bench holds r_ready_i low with a second query pending, then raises it. It judges that the second result appears exactly one cycle later and carries its own type, not the first one.

// File: rtl/memtype_pkg.sv
package memtype_pkg;
  localparam int NUM_FIX = 88;
  localparam int IDX_W   = 7;

  localparam logic [7:0] MT_UC   = 8'h00;
  localparam logic [7:0] MT_WT   = 8'h04;
  localparam logic [7:0] MT_WB   = 8'h06;
  localparam logic [7:0] MT_NONE = 8'hFF;

  typedef enum logic [1:0] {
    WK_DEF  = 2'd0,
    WK_FIX  = 2'd1,
    WK_BASE = 2'd2,
    WK_MASK = 2'd3
  } wr_kind_e;

  // precedence merge of two matching range types
  function automatic logic [7:0] merge_type(input logic [7:0] a, input logic [7:0] b);
    if (a == MT_UC || b == MT_UC) return MT_UC;
    if ((a == MT_WB && b == MT_WT) || (a == MT_WT && b == MT_WB)) return MT_WT;
    if (a != b) return MT_UC;
    return a;
  endfunction
endpackage

// File: rtl/memtype_regs.sv
module memtype_regs
  import memtype_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_VAR = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [1:0]                      wr_kind_i,
  input  logic [IDX_W-1:0]                wr_idx_i,
  input  logic [ADDR_W-1:0]               wr_data_i,
  output logic                            loaded_o,
  output logic                            glob_en_o,
  output logic                            fix_en_o,
  output logic [7:0]                      def_type_o,
  output logic [NUM_FIX-1:0][7:0]         fix_o,
  output logic [NUM_VAR-1:0][ADDR_W-1:0]  base_o,
  output logic [NUM_VAR-1:0][ADDR_W-1:0]  mask_o
);
  logic wr_def, wr_fix, wr_base, wr_mask;
  assign wr_def  = wr_en_i && (wr_kind_i == WK_DEF);
  assign wr_fix  = wr_en_i && (wr_kind_i == WK_FIX);
  assign wr_base = wr_en_i && (wr_kind_i == WK_BASE);
  assign wr_mask = wr_en_i && (wr_kind_i == WK_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_o   <= 1'b0;
      glob_en_o  <= 1'b0;
      fix_en_o   <= 1'b0;
      def_type_o <= '0;
    end else if (wr_def) begin
      loaded_o   <= 1'b1;
      glob_en_o  <= wr_data_i[11];
      fix_en_o   <= wr_data_i[10];
      def_type_o <= wr_data_i[7:0];
    end
  end

  for (genvar g = 0; g < NUM_FIX; g++) begin : g_fix
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) fix_o[g] <= '0;
      else if (wr_fix && wr_idx_i == IDX_W'(g)) fix_o[g] <= wr_data_i[7:0];
    end
  end

  for (genvar v = 0; v < NUM_VAR; v++) begin : g_var
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[v] <= '0;
        mask_o[v] <= '0;
      end else begin
        if (wr_base && wr_idx_i == IDX_W'(v)) base_o[v] <= wr_data_i;
        if (wr_mask && wr_idx_i == IDX_W'(v)) mask_o[v] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/memtype_fixed_sel.sv
module memtype_fixed_sel
  import memtype_pkg::*;
(
  input  logic [7:0]              page_i,  // start[19:12]
  input  logic [NUM_FIX-1:0][7:0] fix_i,
  output logic [7:0]              type_o
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    if (!page_i[7])                idx = IDX_W'(page_i[6:4]);          // 64 KiB granules
    else if (page_i[7:6] == 2'b10) idx = IDX_W'(8) + IDX_W'(page_i[5:2]);  // 16 KiB
    else                           idx = IDX_W'(24) + IDX_W'(page_i[5:0]); // 4 KiB
  end

  assign type_o = fix_i[idx];
endmodule

// File: rtl/memtype_var_scan.sv
module memtype_var_scan
  import memtype_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_VAR    = 8,
  parameter int PAGE_SHIFT = 12,
  parameter int VLD_BIT    = 11
) (
  input  logic [ADDR_W-1:0]               start_i,
  input  logic [ADDR_W-1:0]               end_i,
  input  logic [NUM_VAR-1:0][ADDR_W-1:0]  base_i,
  input  logic [NUM_VAR-1:0][ADDR_W-1:0]  mask_i,
  output logic                            hit_o,
  output logic [7:0]                      type_o,
  output logic                            split_o,
  output logic [ADDR_W-1:0]               part_end_o
);
  localparam logic [ADDR_W-1:0] PG_MASK  = ~((ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] PG_BYTES = ADDR_W'(1) << PAGE_SHIFT;

  logic [ADDR_W-1:0] end_w, m, b, cand;
  logic              s_in, e_in, stop;

  // ordered scan; a split shrinks the end seen by later ranges
  always_comb begin
    end_w      = end_i;
    hit_o      = 1'b0;
    type_o     = MT_NONE;
    split_o    = 1'b0;
    part_end_o = '0;
    stop       = 1'b0;
    m          = '0;
    b          = '0;
    s_in       = 1'b0;
    e_in       = 1'b0;
    cand       = '0;
    for (int i = 0; i < NUM_VAR; i++) begin
      m    = mask_i[i] & PG_MASK;
      b    = base_i[i] & PG_MASK;
      s_in = (start_i & m) == (b & m);
      e_in = (end_w & m) == (b & m);
      cand = s_in ? (b + (~m + ADDR_W'(1))) : b;
      if (cand <= start_i) cand = start_i + PG_BYTES;
      if (!stop && mask_i[i][VLD_BIT]) begin
        if (s_in != e_in) begin
          split_o    = 1'b1;
          part_end_o = cand;
          end_w      = cand - ADDR_W'(1);
        end
        if (s_in) begin
          if (!hit_o) begin
            hit_o  = 1'b1;
            type_o = base_i[i][7:0];
          end else begin
            type_o = merge_type(type_o, base_i[i][7:0]);
            if (type_o == MT_UC) stop = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/memtype_lookup.sv
module memtype_lookup
  import memtype_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_VAR    = 8,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_kind_i,
  input  logic [6:0]        wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              q_valid_i,
  output logic              q_ready_o,
  input  logic [ADDR_W-1:0] q_start_i,
  input  logic [ADDR_W-1:0] q_end_i,
  output logic              r_valid_o,
  input  logic              r_ready_i,
  output logic [7:0]        r_type_o,
  output logic              r_split_o,
  output logic [ADDR_W-1:0] r_part_end_o
);
  logic                           loaded_w, glob_en_w, fix_en_w;
  logic [7:0]                     def_type_w, fix_type_w, var_type_w;
  logic [NUM_FIX-1:0][7:0]        fix_w;
  logic [NUM_VAR-1:0][ADDR_W-1:0] base_w, mask_w;
  logic                           var_hit_w, var_split_w;
  logic [ADDR_W-1:0]              var_pend_w;
  logic                           in_fixed, accept;
  logic [7:0]                     n_type;
  logic                           n_split;
  logic [ADDR_W-1:0]              n_pend;

  memtype_regs #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_kind_i,
    .wr_idx_i   (wr_idx_i),
    .wr_data_i,
    .loaded_o   (loaded_w),
    .glob_en_o  (glob_en_w),
    .fix_en_o   (fix_en_w),
    .def_type_o (def_type_w),
    .fix_o      (fix_w),
    .base_o     (base_w),
    .mask_o     (mask_w)
  );

  memtype_fixed_sel u_fix (
    .page_i (q_start_i[19:12]),
    .fix_i  (fix_w),
    .type_o (fix_type_w)
  );

  memtype_var_scan #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR), .PAGE_SHIFT(PAGE_SHIFT)) u_scan (
    .start_i    (q_start_i),
    .end_i      (q_end_i),
    .base_i     (base_w),
    .mask_i     (mask_w),
    .hit_o      (var_hit_w),
    .type_o     (var_type_w),
    .split_o    (var_split_w),
    .part_end_o (var_pend_w)
  );

  assign in_fixed = fix_en_w && (q_start_i[ADDR_W-1:20] == '0);

  always_comb begin
    n_type  = MT_NONE;
    n_split = 1'b0;
    n_pend  = '0;
    if (loaded_w && glob_en_w) begin
      if (in_fixed) begin
        n_type = fix_type_w;
      end else begin
        n_type  = var_hit_w ? var_type_w : def_type_w;
        n_split = var_split_w;
        n_pend  = var_pend_w;
      end
    end
  end

  assign q_ready_o = !r_valid_o || r_ready_i;
  assign accept    = q_valid_i && q_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_valid_o    <= 1'b0;
      r_type_o     <= '0;
      r_split_o    <= 1'b0;
      r_part_end_o <= '0;
    end else if (accept) begin
      r_valid_o    <= 1'b1;
      r_type_o     <= n_type;
      r_split_o    <= n_split;
      r_part_end_o <= n_pend;
    end else if (r_ready_i) begin
      r_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/memtype_lookup_chk.sv
module memtype_lookup_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              q_valid_i,
  input logic              q_ready_o,
  input logic [ADDR_W-1:0] q_start_i,
  input logic              r_valid_o,
  input logic              r_ready_i,
  input logic [7:0]        r_type_o,
  input logic              r_split_o,
  input logic [ADDR_W-1:0] r_part_end_o,
  input logic              glob_en_w,
  input logic              loaded_w
);
  // R1
  reset_empty_chk: assert property (@(posedge clk_i) !rst_ni |-> !r_valid_o);

  // R12
  accept_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_valid_i && q_ready_o) |=> r_valid_o);

  // R12
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_valid_o && !r_ready_i) |=> (r_valid_o && $stable(r_type_o) && $stable(r_split_o)
                                   && $stable(r_part_end_o)));

  // R12
  stall_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_valid_o && !r_ready_i) |-> !q_ready_o);

  // R2
  disabled_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_valid_i && q_ready_o && !(glob_en_w && loaded_w)) |=> (r_type_o == 8'hFF && !r_split_o));

  // R11
  progress_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_valid_i && q_ready_o) |=> (!r_split_o || r_part_end_o > $past(q_start_i)));
endmodule

bind memtype_lookup memtype_lookup_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .q_valid_i    (q_valid_i),
  .q_ready_o    (q_ready_o),
  .q_start_i    (q_start_i),
  .r_valid_o    (r_valid_o),
  .r_ready_i    (r_ready_i),
  .r_type_o     (r_type_o),
  .r_split_o    (r_split_o),
  .r_part_end_o (r_part_end_o),
  .glob_en_w    (glob_en_w),
  .loaded_w     (loaded_w)
);

// File: tb/memtype_lookup_tb.sv
module memtype_lookup_tb;
  localparam int AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    wr_kind_i = '0;
  logic [6:0]    wr_idx_i = '0;
  logic [AW-1:0] wr_data_i = '0;
  logic          q_valid_i = 1'b0;
  logic          q_ready_o;
  logic [AW-1:0] q_start_i = '0;
  logic [AW-1:0] q_end_i = '0;
  logic          r_valid_o;
  logic          r_ready_i = 1'b1;
  logic [7:0]    r_type_o;
  logic          r_split_o;
  logic [AW-1:0] r_part_end_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  memtype_lookup u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] k, input int idx, input logic [AW-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_kind_i = k; wr_idx_i = 7'(idx); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // issue one query, sample the result one cycle after acceptance
  task automatic query(input logic [AW-1:0] s, input logic [AW-1:0] e);
    @(negedge clk_i);
    q_valid_i = 1'b1; q_start_i = s; q_end_i = e;
    while (!q_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    q_valid_i = 1'b0;
  endtask

  function automatic logic [7:0] fix_val(input int i);
    return 8'((i * 3 + 1) & 255);
  endfunction

  function automatic int fix_index(input logic [AW-1:0] a);
    if (a < 32'h80000) return int'(a >> 16);
    if (a < 32'hC0000) return 8 + int'((a - 32'h80000) >> 14);
    return 24 + int'((a - 32'hC0000) >> 12);
  endfunction

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    repeat (2) @(negedge clk_i);
    // R1 reset state
    chk("R1 r_valid", r_valid_o, 0);
    chk("R1 q_ready", q_ready_o, 1);
    rst_ni = 1'b1;
    for (int i = 0; i < 88; i++) wr(2'd1, i, AW'(fix_val(i)));
    query(32'h10000, 32'h10FFF);
    chk("R1 unloaded type", r_type_o, 8'hFF);
    chk("R1 unloaded split", r_split_o, 0);

    // fixed ranges on, default write-back (encoding: bit11 global, bit10 fixed, 7:0 type)
    wr(2'd0, 0, 32'hC06);
    for (int p = 0; p < 256; p++) begin
      a = (AW'(p) << 12) | AW'((p * 37) & 32'hFFF);
      query(a, a);
      if (a < 32'h80000)      chk("R3 64K entry", r_type_o, fix_val(fix_index(a)));
      else if (a < 32'hC0000) chk("R4 16K entry", r_type_o, fix_val(fix_index(a)));
      else                    chk("R5 4K entry", r_type_o, fix_val(fix_index(a)));
    end
    query(32'h100000, 32'h100FFF);
    chk("R8 above fixed", r_type_o, 8'h06);

    // R13 write and query on the same edge
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_kind_i = 2'd1; wr_idx_i = 7'd0; wr_data_i = 32'h55;
    q_valid_i = 1'b1; q_start_i = 32'h0; q_end_i = 32'hFFF;
    @(negedge clk_i);
    wr_en_i = 1'b0; q_valid_i = 1'b0;
    chk("R13 old state", r_type_o, fix_val(0));
    query(32'h0, 32'hFFF);
    chk("R13 new state", r_type_o, 8'h55);

    // R6 fixed disabled
    wr(2'd0, 0, 32'h806);
    query(32'h0, 32'hFFF);
    chk("R6 fixed ignored", r_type_o, 8'h06);
    query(32'h12345000, 32'h12345FFF);
    chk("R8 no match", r_type_o, 8'h06);

    // range0: 256 MiB write-through at 0x10000000
    wr(2'd2, 0, 32'h1000_0004);
    wr(2'd3, 0, 32'hF000_0800);
    query(32'h10001000, 32'h10001FFF);
    chk("R7 match type", r_type_o, 8'h04);
    chk("R7 no split", r_split_o, 0);
    wr(2'd2, 1, 32'h1000_0000);
    wr(2'd3, 1, 32'hFFF0_0000);
    query(32'h10001000, 32'h10001FFF);
    chk("R7 inactive range", r_type_o, 8'h04);
    wr(2'd2, 1, 32'h1000_0006);
    wr(2'd3, 1, 32'hFFF0_0800);
    query(32'h10001000, 32'h10001FFF);
    chk("R9 WB+WT", r_type_o, 8'h04);
    wr(2'd2, 1, 32'h1000_0000);
    query(32'h10001000, 32'h10001FFF);
    chk("R9 UC wins", r_type_o, 8'h00);
    wr(2'd2, 1, 32'h1000_0001);
    query(32'h10001000, 32'h10001FFF);
    chk("R9 differing", r_type_o, 8'h00);
    wr(2'd2, 1, 32'h1000_0004);
    query(32'h10001000, 32'h10001FFF);
    chk("R9 equal", r_type_o, 8'h04);
    wr(2'd3, 1, 32'h0);

    // R10 splits
    query(32'h0FFFF000, 32'h10000FFF);
    chk("R10 below type", r_type_o, 8'h06);
    chk("R10 below split", r_split_o, 1);
    chk("R10 below pend", r_part_end_o, 32'h10000000);
    query(32'h1FFFF000, 32'h20000FFF);
    chk("R10 above type", r_type_o, 8'h04);
    chk("R10 above split", r_split_o, 1);
    chk("R10 above pend", r_part_end_o, 32'h20000000);
    // R11 split point behind start
    query(32'h30000000, 32'h10000000);
    chk("R11 split", r_split_o, 1);
    chk("R11 pend", r_part_end_o, 32'h30001000);
    chk("R11 type", r_type_o, 8'h06);

    // R12 stall then release with a waiting query
    @(negedge clk_i);
    r_ready_i = 1'b0;
    q_valid_i = 1'b1; q_start_i = 32'h10001000; q_end_i = 32'h10001FFF;
    @(negedge clk_i);
    q_start_i = 32'h50000000; q_end_i = 32'h50000FFF;
    chk("R12 valid", r_valid_o, 1);
    chk("R12 ready low", q_ready_o, 0);
    repeat (3) @(negedge clk_i);
    chk("R12 held valid", r_valid_o, 1);
    chk("R12 held type", r_type_o, 8'h04);
    r_ready_i = 1'b1;
    @(negedge clk_i);
    q_valid_i = 1'b0;
    chk("R12 next valid", r_valid_o, 1);
    chk("R12 next type", r_type_o, 8'h06);

    // R2 global enable off
    wr(2'd0, 0, 32'h406);
    query(32'h10001000, 32'h10001FFF);
    chk("R2 var type", r_type_o, 8'hFF);
    chk("R2 split", r_split_o, 0);
    query(32'h0, 32'hFFF);
    chk("R2 fixed type", r_type_o, 8'hFF);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule